// File: doc/BRIEF.md
# Slot Schedule Generator

This engine builds the rotating slot table of a memory arbiter. Each of up to `MAX_CLIENTS` clients carries a requested slot count and an active flag. On a start pulse the engine fills a `NUM_SLOTS`-entry table in three passes:

- It places the clients that asked for bandwidth.
- It hands single spare slots to active clients that asked for none.
- It fills every remaining hole round-robin across the active clients.

Once the table is complete, it streams the entries in slot order to the arbiter's slot-table write port, one entry per cycle, and then signals completion.

A combinational admission checker sits beside the engine. It turns a bandwidth figure into a slot count, scaled against the maximum bandwidth of the memory region. It flags the request as rejected when adding that count to the slots already handed out would overfill the table. Software uses it to decide whether to rewrite the request array before starting a new run.

Top module: `sched_gen`

## Requirements
- R1: While in reset and after it, with no start seen, `busy`, `wr_valid` and `done` are all low.
- R2: A `start` pulse while idle begins a run: `busy` is high from the next cycle until the cycle after `done`. A `start` pulse while `busy` is high is ignored, so no second stream follows.
- R3: Clients below `num_clients` that have a nonzero request are handled in ascending index order, whatever their active flag.
  - Each uses a stride of `NUM_SLOTS / request`, truncated. A stride of 0 becomes 1.
  - A scan starts at slot 0. An occupied slot moves it on by one. A free slot is given to the client and the scan jumps ahead by the stride. The scan stops at slot `NUM_SLOTS` or beyond.
- R4: A client with a zero request, active flag 1 and a spare count (latched from `spare_slots` at start) above zero gets exactly one slot, the first free one. The spare count then drops by one. Zero-request clients that are inactive, or that come after the spare count reaches zero, get nothing in this pass.
- R5: After the placement passes, each slot still free is filled in slot order from a rotating pointer that starts at 0. The slot gets the first active client at or after the pointer, searching upward modulo `num_clients`. The pointer then becomes that client plus one, modulo `num_clients`.
- R6: If no client below `num_clients` is active, a free slot gets the pointer's own value, and the pointer advances by one modulo `num_clients`.
- R7: The finished table leaves as exactly `NUM_SLOTS` beats on consecutive cycles. Each beat has `wr_valid` high, `wr_slot` counting 0 upward and `wr_client` holding that slot's client, which is always below `num_clients`.
- R8: `done` is high for exactly one cycle, the cycle right after the beat for the last slot. `busy` is low in the following cycle.
- R9: The admission slot count is 0 when `adm_bw` is 0. Otherwise, with q = `adm_max_bw / adm_bw` truncated, it is `NUM_SLOTS` when q is 0 and `NUM_SLOTS / q`, truncated, when q is nonzero.
- R10: `adm_reject` is high exactly when `adm_assigned` plus the admission slot count exceeds `NUM_SLOTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin building a table |
| num_clients | input | NCL_W (5) | Number of clients in use, 1..MAX_CLIENTS; latched at start |
| req_slots | input | MAX_CLIENTS*CNT_W (112) | Requested slot count per client, client c at bits [c*CNT_W +: CNT_W]; held during a run |
| active | input | MAX_CLIENTS (16) | Active flag per client, bit c for client c; held during a run |
| spare_slots | input | CNT_W (7) | Slots free for zero-request clients; latched at start |
| busy | output | 1 | High while a run is in progress |
| wr_valid | output | 1 | Slot-table write beat valid |
| wr_slot | output | SLOT_W (6) | Slot index of the beat |
| wr_client | output | CID_W (4) | Client owning that slot |
| done | output | 1 | One-cycle pulse after the last beat |
| adm_bw | input | BW_W (16) | Bandwidth asked for |
| adm_max_bw | input | BW_W (16) | Maximum bandwidth of the region |
| adm_assigned | input | CNT_W (7) | Slots already assigned |
| adm_slots | output | CNT_W (7) | Slot count for the request |
| adm_reject | output | 1 | Request would overfill the table |

## Verification
A wrong occupancy bit or a misplaced stride jump inside the placement pass stays hidden until streaming. It then shows as a wrong `wr_client` at a specific `wr_slot`, at least about 65 cycles after the fault. The bench therefore compares every one of the 64 beats against an independently built table.

A corrupted round-robin pointer shows as a run of clients shifted by one across the filled holes. A bad sequencer state shows as a missing, repeated or out-of-order `wr_slot`, or as `done` landing off the cycle after the last beat.

The admission path is combinational, so a fault there appears on `adm_slots` and `adm_reject` in the same cycle its inputs change.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PLACE = 3'd1,
    ST_FILL  = 3'd2,
    ST_EMIT  = 3'd3,
    ST_DONE  = 3'd4
  } sched_state_e;
endpackage

// File: rtl/sched_table.sv
module sched_table #(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = 6,
  parameter int CID_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [SLOT_W-1:0]    waddr,
  input  logic [CID_W-1:0]     wdata,
  input  logic [SLOT_W-1:0]    raddr,
  output logic [CID_W-1:0]     rdata,
  output logic [NUM_SLOTS-1:0] occ
);
  logic [NUM_SLOTS-1:0] occ_q, occ_d;
  logic [CID_W-1:0]     owner_q [NUM_SLOTS];

  // occupancy marks which slots already hold a client
  always_comb begin
    occ_d = occ_q;
    if (clr) begin
      occ_d = '0;
    end else if (we) begin
      occ_d[waddr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else begin
      occ_q <= occ_d;
    end
  end

  // owner storage needs no reset: an entry is read only after it is written
  always_ff @(posedge clk) begin
    if (we) begin
      owner_q[waddr] <= wdata;
    end
  end

  assign rdata = owner_q[raddr];
  assign occ   = occ_q;
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int MAX_CLIENTS = 16,
  parameter int CID_W       = 4,
  parameter int NCL_W       = 5
) (
  input  logic [MAX_CLIENTS-1:0] active,
  input  logic [CID_W-1:0]       ptr,
  input  logic [NCL_W-1:0]       n,
  output logic [CID_W-1:0]       pick,
  output logic [CID_W-1:0]       ptr_next
);
  logic [NCL_W:0] cand;
  logic [NCL_W:0] nxt;
  logic           found;

  always_comb begin
    pick  = ptr;
    found = 1'b0;
    cand  = '0;
    for (int k = 0; k < MAX_CLIENTS; k++) begin
      if (!found && (NCL_W'(k) < n)) begin
        cand = (NCL_W+1)'(ptr) + (NCL_W+1)'(k);
        if (cand >= (NCL_W+1)'(n)) begin
          cand = cand - (NCL_W+1)'(n);
        end
        if (active[cand[CID_W-1:0]]) begin
          pick  = cand[CID_W-1:0];
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    nxt = (NCL_W+1)'(pick) + (NCL_W+1)'(1);
    if (nxt >= (NCL_W+1)'(n)) begin
      ptr_next = '0;
    end else begin
      ptr_next = nxt[CID_W-1:0];
    end
  end
endmodule

// File: rtl/sched_admit.sv
module sched_admit #(
  parameter int NUM_SLOTS = 64,
  parameter int CNT_W     = 7,
  parameter int BW_W      = 16
) (
  input  logic [BW_W-1:0]  bw,
  input  logic [BW_W-1:0]  max_bw,
  input  logic [CNT_W-1:0] assigned,
  output logic [CNT_W-1:0] slots,
  output logic             reject
);
  logic [BW_W-1:0]  ratio;
  logic [BW_W-1:0]  share;
  logic [CNT_W:0]   total;

  always_comb begin
    ratio = '0;
    share = '0;
    if (bw != '0) begin
      ratio = max_bw / bw;
      if (ratio == '0) begin
        share = BW_W'(NUM_SLOTS);
      end else begin
        share = BW_W'(NUM_SLOTS) / ratio;
      end
    end
    slots  = share[CNT_W-1:0];
    total  = (CNT_W+1)'(assigned) + (CNT_W+1)'(slots);
    reject = total > (CNT_W+1)'(NUM_SLOTS);
  end
endmodule

// File: rtl/sched_gen.sv
module sched_gen
  import sched_pkg::*;
#(
  parameter  int NUM_SLOTS   = 64,
  parameter  int MAX_CLIENTS = 16,
  parameter  int BW_W        = 16,
  localparam int SLOT_W      = $clog2(NUM_SLOTS),
  localparam int CNT_W       = SLOT_W + 1,
  localparam int CID_W       = $clog2(MAX_CLIENTS),
  localparam int NCL_W       = $clog2(MAX_CLIENTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [NCL_W-1:0]             num_clients,
  input  logic [MAX_CLIENTS*CNT_W-1:0] req_slots,
  input  logic [MAX_CLIENTS-1:0]       active,
  input  logic [CNT_W-1:0]             spare_slots,
  output logic                         busy,
  output logic                         wr_valid,
  output logic [SLOT_W-1:0]            wr_slot,
  output logic [CID_W-1:0]             wr_client,
  output logic                         done,
  input  logic [BW_W-1:0]              adm_bw,
  input  logic [BW_W-1:0]              adm_max_bw,
  input  logic [CNT_W-1:0]             adm_assigned,
  output logic [CNT_W-1:0]             adm_slots,
  output logic                         adm_reject
);
  localparam logic [CNT_W-1:0] SLOTS_V = CNT_W'(NUM_SLOTS);

  // reset: asserted at once, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  logic [CNT_W-1:0] req_arr [MAX_CLIENTS];
  for (genvar c = 0; c < MAX_CLIENTS; c++) begin : g_req
    assign req_arr[c] = req_slots[c*CNT_W +: CNT_W];
  end

  sched_state_e     state_q, state_d;
  logic [NCL_W-1:0] cli_q, cli_d;
  logic [NCL_W-1:0] n_q, n_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] iv_q, iv_d;
  logic             scan_q, scan_d;
  logic [CNT_W-1:0] spare_q, spare_d;
  logic [CID_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] slot_q, slot_d;

  logic                 tbl_clr, tbl_we;
  logic [SLOT_W-1:0]    tbl_waddr;
  logic [CID_W-1:0]     tbl_wdata, tbl_rdata;
  logic [NUM_SLOTS-1:0] occ;
  logic [CID_W-1:0]     rr_pick, rr_next;

  logic [CNT_W-1:0] cur_req, req_quo, req_iv;
  logic             cur_act;

  sched_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CID_W(CID_W)) u_table (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (tbl_clr),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (slot_q[SLOT_W-1:0]),
    .rdata (tbl_rdata),
    .occ   (occ)
  );

  sched_rr_pick #(.MAX_CLIENTS(MAX_CLIENTS), .CID_W(CID_W), .NCL_W(NCL_W)) u_rr (
    .active   (active),
    .ptr      (ptr_q),
    .n        (n_q),
    .pick     (rr_pick),
    .ptr_next (rr_next)
  );

  sched_admit #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .BW_W(BW_W)) u_admit (
    .bw       (adm_bw),
    .max_bw   (adm_max_bw),
    .assigned (adm_assigned),
    .slots    (adm_slots),
    .reject   (adm_reject)
  );

  // stride of the client under evaluation, never below one
  always_comb begin
    cur_req = req_arr[cli_q[CID_W-1:0]];
    cur_act = active[cli_q[CID_W-1:0]];
    req_quo = (cur_req != '0) ? (SLOTS_V / cur_req) : '0;
    req_iv  = (req_quo == '0) ? CNT_W'(1) : req_quo;
  end

  always_comb begin
    state_d   = state_q;
    cli_d     = cli_q;
    n_d       = n_q;
    pos_d     = pos_q;
    iv_d      = iv_q;
    scan_d    = scan_q;
    spare_d   = spare_q;
    ptr_d     = ptr_q;
    slot_d    = slot_q;
    tbl_clr   = 1'b0;
    tbl_we    = 1'b0;
    tbl_waddr = pos_q[SLOT_W-1:0];
    tbl_wdata = cli_q[CID_W-1:0];
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PLACE;
          tbl_clr = 1'b1;
          cli_d   = '0;
          scan_d  = 1'b0;
          n_d     = num_clients;
          spare_d = spare_slots;
        end
      end
      ST_PLACE: begin
        if (!scan_q) begin
          if (cli_q == n_q) begin
            state_d = ST_FILL;
            slot_d  = '0;
            ptr_d   = '0;
          end else if (cur_req != '0) begin
            iv_d   = req_iv;
            pos_d  = '0;
            scan_d = 1'b1;
          end else if (cur_act && (spare_q != '0)) begin
            spare_d = spare_q - CNT_W'(1);
            iv_d    = SLOTS_V;
            pos_d   = '0;
            scan_d  = 1'b1;
          end else begin
            cli_d = cli_q + NCL_W'(1);
          end
        end else begin
          if (pos_q >= SLOTS_V) begin
            scan_d = 1'b0;
            cli_d  = cli_q + NCL_W'(1);
          end else if (occ[pos_q[SLOT_W-1:0]]) begin
            pos_d = pos_q + CNT_W'(1);
          end else begin
            tbl_we = 1'b1;
            pos_d  = pos_q + iv_q;
          end
        end
      end
      ST_FILL: begin
        if (slot_q == SLOTS_V) begin
          state_d = ST_EMIT;
          slot_d  = '0;
        end else begin
          if (!occ[slot_q[SLOT_W-1:0]]) begin
            tbl_we    = 1'b1;
            tbl_waddr = slot_q[SLOT_W-1:0];
            tbl_wdata = rr_pick;
            ptr_d     = rr_next;
          end
          slot_d = slot_q + CNT_W'(1);
        end
      end
      ST_EMIT: begin
        slot_d = slot_q + CNT_W'(1);
        if (slot_q == SLOTS_V - CNT_W'(1)) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cli_q   <= '0;
      n_q     <= '0;
      pos_q   <= '0;
      iv_q    <= '0;
      scan_q  <= 1'b0;
      spare_q <= '0;
      ptr_q   <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      cli_q   <= cli_d;
      n_q     <= n_d;
      pos_q   <= pos_d;
      iv_q    <= iv_d;
      scan_q  <= scan_d;
      spare_q <= spare_d;
      ptr_q   <= ptr_d;
      slot_q  <= slot_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign wr_valid  = (state_q == ST_EMIT);
  assign wr_slot   = slot_q[SLOT_W-1:0];
  assign wr_client = tbl_rdata;
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/sched_gen_chk.sv
module sched_gen_chk #(
  parameter  int NUM_SLOTS   = 64,
  parameter  int MAX_CLIENTS = 16,
  parameter  int BW_W        = 16,
  localparam int SLOT_W      = $clog2(NUM_SLOTS),
  localparam int CNT_W       = SLOT_W + 1,
  localparam int CID_W       = $clog2(MAX_CLIENTS),
  localparam int NCL_W       = $clog2(MAX_CLIENTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [NCL_W-1:0]  num_clients,
  input logic              busy,
  input logic              wr_valid,
  input logic [SLOT_W-1:0] wr_slot,
  input logic [CID_W-1:0]  wr_client,
  input logic              done,
  input logic [BW_W-1:0]   adm_bw,
  input logic [CNT_W-1:0]  adm_assigned,
  input logic              adm_reject
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !done));

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R7
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_slot != LAST_SLOT) |=> (wr_valid && wr_slot == $past(wr_slot) + SLOT_W'(1)));

  // R7
  client_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (NCL_W'(wr_client) < num_clients));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_slot == LAST_SLOT) |=> (done && !wr_valid));

  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  zero_bw_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adm_bw == '0 && adm_assigned <= CNT_W'(NUM_SLOTS)) |-> !adm_reject);
endmodule

bind sched_gen sched_gen_chk #(
  .NUM_SLOTS   (NUM_SLOTS),
  .MAX_CLIENTS (MAX_CLIENTS),
  .BW_W        (BW_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .num_clients  (num_clients),
  .busy         (busy),
  .wr_valid     (wr_valid),
  .wr_slot      (wr_slot),
  .wr_client    (wr_client),
  .done         (done),
  .adm_bw       (adm_bw),
  .adm_assigned (adm_assigned),
  .adm_reject   (adm_reject)
);

// File: tb/tb_sched_gen.sv
module tb_sched_gen;
  localparam int NS    = 64;
  localparam int MC    = 16;
  localparam int BW_W  = 16;
  localparam int CNT_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [4:0]        num_clients = 5'd1;
  logic [MC*CNT_W-1:0] req_slots = '0;
  logic [MC-1:0]     active = '0;
  logic [CNT_W-1:0]  spare_slots = '0;
  logic              busy, wr_valid, done;
  logic [5:0]        wr_slot;
  logic [3:0]        wr_client;
  logic [BW_W-1:0]   adm_bw = '0, adm_max_bw = '0;
  logic [CNT_W-1:0]  adm_assigned = '0;
  logic [CNT_W-1:0]  adm_slots;
  logic              adm_reject;

  int checks = 0;
  int failures = 0;
  int req_v [MC];
  int act_v [MC];
  int n_v;
  int spare_v;
  int exp_tbl [NS];

  always #10 clk = ~clk;

  sched_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_clients(num_clients),
    .req_slots(req_slots), .active(active), .spare_slots(spare_slots),
    .busy(busy), .wr_valid(wr_valid), .wr_slot(wr_slot), .wr_client(wr_client),
    .done(done), .adm_bw(adm_bw), .adm_max_bw(adm_max_bw),
    .adm_assigned(adm_assigned), .adm_slots(adm_slots), .adm_reject(adm_reject)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected table, built from R3..R6
  task automatic build_expected();
    int occ [NS];
    int spare, iv, pos, ptr, found, cand;
    spare = spare_v;
    for (int s = 0; s < NS; s++) begin occ[s] = 0; exp_tbl[s] = -1; end
    for (int c = 0; c < n_v; c++) begin
      if (req_v[c] != 0) begin
        iv = NS / req_v[c];
        if (iv == 0) iv = 1;
      end else if (act_v[c] != 0 && spare > 0) begin
        spare--;
        iv = NS;
      end else begin
        continue;
      end
      pos = 0;
      while (pos < NS) begin
        if (occ[pos] != 0) pos++;
        else begin exp_tbl[pos] = c; occ[pos] = 1; pos += iv; end
      end
    end
    ptr = 0;
    for (int s = 0; s < NS; s++) begin
      if (occ[s] == 0) begin
        found = -1;
        for (int k = 0; k < n_v; k++) begin
          cand = (ptr + k) % n_v;
          if (found < 0 && act_v[cand] != 0) found = cand;
        end
        if (found < 0) found = ptr;
        exp_tbl[s] = found;
        ptr = (found + 1) % n_v;
      end
    end
  endtask

  task automatic do_run(input string tag);
    int beats, cyc;
    bit got_done, prev_last;
    @(negedge clk);
    num_clients = 5'(n_v);
    spare_slots = CNT_W'(spare_v);
    for (int c = 0; c < MC; c++) begin
      req_slots[c*CNT_W +: CNT_W] = CNT_W'(req_v[c]);
      active[c] = (act_v[c] != 0);
    end
    build_expected();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    beats = 0; cyc = 0; got_done = 0; prev_last = 0;
    while (!got_done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == 3);  // R2: this pulse lands while busy and must be ignored
      if (done) begin
        chk(beats == NS, "R7 beat count", beats, NS);
        chk(prev_last, "R8 done right after last beat", int'(prev_last), 1);
        got_done = 1;
      end
      prev_last = 0;
      if (wr_valid) begin
        chk(int'(wr_slot) == beats, "R7 slot order", int'(wr_slot), beats);
        chk(int'(wr_client) == exp_tbl[beats], tag, int'(wr_client), exp_tbl[beats]);
        prev_last = (beats == NS - 1);
        beats++;
      end
    end
    start = 1'b0;
    chk(got_done, "R8 run finished", int'(got_done), 1);
    @(negedge clk);
    chk(busy === 1'b0, "R8 idle after done", int'(busy), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy && !wr_valid && !done, "R2 ignored start caused no rerun", int'(busy), 0);
    end
  endtask

  task automatic adm_case(input int bw, input int mx, input int asg);
    int q, es, er;
    @(negedge clk);
    adm_bw = BW_W'(bw);
    adm_max_bw = BW_W'(mx);
    adm_assigned = CNT_W'(asg);
    #1;
    if (bw == 0) es = 0;
    else begin
      q = mx / bw;
      es = (q == 0) ? NS : NS / q;
    end
    er = (asg + es > NS) ? 1 : 0;
    chk(int'(adm_slots) == es, "R9 admission slots", int'(adm_slots), es);
    chk(int'(adm_reject) == er, "R10 admission reject", int'(adm_reject), er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !done, "R1 state in reset", int'(busy | wr_valid | done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !wr_valid && !done, "R1 state after reset", int'(busy | wr_valid | done), 0);

    // R6: no active client, no requests
    n_v = 5; spare_v = 3;
    for (int c = 0; c < MC; c++) begin req_v[c] = 0; act_v[c] = 0; end
    do_run("R6 fallback to pointer");

    // R3: client 0 takes every slot
    n_v = 3; spare_v = 0;
    for (int c = 0; c < MC; c++) begin req_v[c] = 0; act_v[c] = 1; end
    req_v[0] = 64;
    do_run("R3 full request");

    // R3: strides 32 and 21 with collisions at slot 0
    n_v = 4; spare_v = 0;
    for (int c = 0; c < MC; c++) begin req_v[c] = 0; act_v[c] = 0; end
    req_v[0] = 2; req_v[1] = 3; act_v[3] = 1;
    do_run("R3 stride placement");

    // R4: only the first zero-request active client gets a spare slot
    n_v = 4; spare_v = 1;
    for (int c = 0; c < MC; c++) begin req_v[c] = 0; act_v[c] = 1; end
    act_v[0] = 0;
    do_run("R4 single spare slot");

    // R3: request above the slot count uses stride one
    n_v = 6; spare_v = 2;
    for (int c = 0; c < MC; c++) begin req_v[c] = 0; act_v[c] = c % 2; end
    req_v[2] = 1; req_v[4] = 90;
    do_run("R3 oversized request");

    for (int t = 0; t < 12; t++) begin
      n_v = 1 + int'($urandom % MC);
      spare_v = int'($urandom % 10);
      for (int c = 0; c < MC; c++) begin
        act_v[c] = int'($urandom % 2);
        r = int'($urandom % 10);
        if (r < 6) req_v[c] = 0;
        else if (r < 9) req_v[c] = 1 + int'($urandom % 8);
        else req_v[c] = 65 + int'($urandom % 20);
      end
      do_run("R5 round-robin mix");
    end

    adm_case(0, 1000, 10);
    adm_case(0, 1000, 70);
    adm_case(2000, 1000, 0);
    adm_case(2000, 1000, 1);
    adm_case(1000, 1000, 0);
    adm_case(250, 1000, 48);
    adm_case(250, 1000, 49);
    for (int t = 0; t < 40; t++) begin
      adm_case(int'($urandom % 4000), 1 + int'($urandom % 60000), int'($urandom % 65));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule